// File: doc/BRIEF.md
# Keyed configuration port controller

This block is the register-access front end of a legacy-style configuration space that a host reaches through two byte-wide I/O locations: an index port, and a data port at the next address up. Out of reset the block is locked. In that state it answers every read with 0xFF and drops every data-port write. Index-port writes go only to a key matcher. When the host writes a correct unlock key to the index port, the block opens. The host then writes a register index to the index port and reads or writes that register through the data port.

A logical device number register chooses which device bank is visible in the upper part of the index space. Each bank holds a small set of read/write bytes. The chip identification bytes and the version nibble are read-only. There are two ways to close the block again: write a fixed command value to a fixed control register, or write a close byte straight to the index port. Address decoding of the base port is done outside the block. A strap input tells the block which of the two base ports is in use, because the last key byte depends on it.

Top module: `keyed_cfg_port`

## Requirements
- R1: While locked, a read of either port returns 0xFF, and a data-port write changes no register. The device-number register is checked afterwards to show this.
- R2: The main key is the index-port byte sequence 0x87, 0x01, 0x55 followed by a final byte. The final byte is 0x55 when altBase=0 and 0xAA when altBase=1. The final byte that belongs to the other base does not unlock the block.
- R3: Two consecutive index-port writes of 0x87 also unlock the block.
- R4: A wrong byte during a key sequence returns the matcher to idle. A wrong byte of 0x87 instead counts as the first byte of a new sequence.
- R5: While unlocked, an index-port write that is not 0xAA loads the index register. An index-port read returns that index (for example, writing 0x20 reads back 0x20).
- R6: Index 0x20 reads the high chip-ID byte (0x87 by default) and 0x21 reads the low byte (0xA5 by default). Index 0x22 reads the version in bits 3..0 (0x3 by default), with bits 7..4 read as zero. Writes to these three indexes are ignored.
- R7: Index 0x07 is the device-number register. Indexes 0x30 to 0x30+BANK_REGS-1 (0x30..0x3F by default) reach the storage of the selected device. Each of the devices 0 through NUM_LDEV-1 (0x0..0xA by default) has its own storage.
- R8: If the device number is NUM_LDEV or above, bank indexes read 0xFF and writes to them are ignored. A bank-range index beyond BANK_REGS also reads 0xFF.
- R9: Writing 0x02 through the data port while the index is 0x02 locks the block. Any other value written to 0x02 leaves the block unlocked.
- R10: Writing 0xAA to the index port while unlocked locks the block.
- R11: When the block locks, the index register clears to 0x00. The device-number register and the bank contents keep their values.
- R12: Read data appears on busRdData at the clock edge that samples busRdEn and holds until the next read. After reset busRdData is 0xFF, the block is locked, and all registers are 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| altBase | input | 1 | Base-port strap: 0 = primary base (final key byte 0x55), 1 = alternate base (0xAA) |
| busWrEn | input | 1 | One-cycle write strobe |
| busRdEn | input | 1 | One-cycle read strobe |
| busAddrSel | input | 1 | 0 = index port, 1 = data port |
| busWrData | input | 8 | Write byte |
| busRdData | output | 8 | Read byte, registered |

## Verification
Every write takes effect at the rising edge that samples its strobe. Every read result is registered at that same edge, so it can be seen one cycle after the strobe is driven. The bench drives each strobe for exactly one cycle, starting at a falling edge. It samples busRdData at the next falling edge, half a cycle after the edge that loaded it. Each effect of a write, including a lock or unlock, is therefore seen by the first read that follows the write. Lock state and any ignored write are observed only through later port reads.

// File: rtl/keyed_cfg_pkg.sv
package keyed_cfg_pkg;

  typedef struct packed {
    logic loadIdx;
    logic clearIdx;
    logic writeReg;
    logic readIdx;
    logic readReg;
    logic readLocked;
  } cfgStrobe_t;

  typedef enum logic [1:0] {
    KEY_IDLE = 2'd0,
    KEY_GOT1 = 2'd1,
    KEY_GOT2 = 2'd2,
    KEY_GOT3 = 2'd3
  } keyState_t;

  localparam logic [7:0] KEY_FIRST      = 8'h87;
  localparam logic [7:0] KEY_SECOND     = 8'h01;
  localparam logic [7:0] KEY_THIRD      = 8'h55;
  localparam logic [7:0] KEY_LAST_MAIN  = 8'h55;
  localparam logic [7:0] KEY_LAST_ALT   = 8'hAA;
  localparam logic [7:0] CLOSE_IDX_BYTE = 8'hAA;
  localparam logic [7:0] CLOSE_REG_IDX  = 8'h02;
  localparam logic [7:0] CLOSE_REG_VAL  = 8'h02;
  localparam logic [7:0] LDN_SEL_IDX    = 8'h07;
  localparam logic [7:0] ID_HIGH_IDX    = 8'h20;
  localparam logic [7:0] ID_LOW_IDX     = 8'h21;
  localparam logic [7:0] VERSION_IDX    = 8'h22;
  localparam logic [7:0] BANK_BASE_IDX  = 8'h30;
  localparam logic [7:0] LOCKED_READ    = 8'hFF;

endpackage

// File: rtl/keyed_cfg_ctrl.sv
module keyed_cfg_ctrl
  import keyed_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       altBase,
  input  logic       busWrEn,
  input  logic       busRdEn,
  input  logic       busAddrSel,
  input  logic [7:0] busWrData,
  input  logic [7:0] curIdx,
  output cfgStrobe_t strobe,
  output logic       cfgOpen
);

  keyState_t keyState, keyNext;
  logic      openNext;
  logic [7:0] lastKeyByte;

  assign lastKeyByte = altBase ? KEY_LAST_ALT : KEY_LAST_MAIN;

  always_comb begin
    strobe   = '0;
    keyNext  = keyState;
    openNext = cfgOpen;

    if (busRdEn) begin
      if (!cfgOpen)        strobe.readLocked = 1'b1;
      else if (busAddrSel) strobe.readReg    = 1'b1;
      else                 strobe.readIdx    = 1'b1;
    end

    if (busWrEn && !busAddrSel) begin
      if (cfgOpen) begin
        if (busWrData == CLOSE_IDX_BYTE) begin
          strobe.clearIdx = 1'b1;
          openNext        = 1'b0;
        end else begin
          strobe.loadIdx = 1'b1;
        end
      end else begin
        unique case (keyState)
          KEY_IDLE: keyNext = (busWrData == KEY_FIRST) ? KEY_GOT1 : KEY_IDLE;
          KEY_GOT1: begin
            if (busWrData == KEY_FIRST) begin
              openNext = 1'b1;
              keyNext  = KEY_IDLE;
            end else if (busWrData == KEY_SECOND) begin
              keyNext = KEY_GOT2;
            end else begin
              keyNext = KEY_IDLE;
            end
          end
          KEY_GOT2: begin
            if (busWrData == KEY_THIRD)      keyNext = KEY_GOT3;
            else if (busWrData == KEY_FIRST) keyNext = KEY_GOT1;
            else                             keyNext = KEY_IDLE;
          end
          KEY_GOT3: begin
            if (busWrData == lastKeyByte) begin
              openNext = 1'b1;
              keyNext  = KEY_IDLE;
            end else if (busWrData == KEY_FIRST) begin
              keyNext = KEY_GOT1;
            end else begin
              keyNext = KEY_IDLE;
            end
          end
          default: keyNext = KEY_IDLE;
        endcase
      end
    end else if (busWrEn && busAddrSel && cfgOpen) begin
      if (curIdx == CLOSE_REG_IDX && busWrData == CLOSE_REG_VAL) begin
        strobe.clearIdx = 1'b1;
        openNext        = 1'b0;
      end else begin
        strobe.writeReg = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyState <= KEY_IDLE;
      cfgOpen  <= 1'b0;
    end else begin
      keyState <= keyNext;
      cfgOpen  <= openNext;
    end
  end

endmodule

// File: rtl/keyed_cfg_dp.sv
module keyed_cfg_dp
  import keyed_cfg_pkg::*;
#(
  parameter int          NUM_LDEV  = 11,
  parameter int          BANK_REGS = 16,
  parameter logic [15:0] CHIP_ID   = 16'h87A5,
  parameter logic [3:0]  CHIP_VER  = 4'h3
) (
  input  logic       clk,
  input  logic       rstN,
  input  cfgStrobe_t strobe,
  input  logic [7:0] busWrData,
  output logic [7:0] busRdData,
  output logic [7:0] curIdx,
  output logic [7:0] curLdn
);

  localparam int BANK_AW = (BANK_REGS > 1) ? $clog2(BANK_REGS) : 1;

  logic [7:0] idxReg, ldnReg, bankOff, regValue, bankValue;
  logic       bankHit, ldnValid, bankWr;
  logic [NUM_LDEV-1:0][7:0] devRd;

  assign curIdx   = idxReg;
  assign curLdn   = ldnReg;
  assign bankOff  = idxReg - BANK_BASE_IDX;
  assign bankHit  = (idxReg >= BANK_BASE_IDX) && (bankOff < 8'(BANK_REGS));
  assign ldnValid = ldnReg < 8'(NUM_LDEV);
  assign bankWr   = strobe.writeReg && bankHit && ldnValid;

  for (genvar d = 0; d < NUM_LDEV; d++) begin : g_dev
    logic [7:0] mem [BANK_REGS];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int r = 0; r < BANK_REGS; r++) mem[r] <= 8'h00;
      end else if (bankWr && ldnReg == 8'(d)) begin
        mem[bankOff[BANK_AW-1:0]] <= busWrData;
      end
    end
    assign devRd[d] = mem[bankOff[BANK_AW-1:0]];
  end

  always_comb begin
    bankValue = LOCKED_READ;
    for (int d = 0; d < NUM_LDEV; d++) begin
      if (ldnReg == 8'(d)) bankValue = devRd[d];
    end
  end

  always_comb begin
    if (idxReg == LDN_SEL_IDX)       regValue = ldnReg;
    else if (idxReg == ID_HIGH_IDX)  regValue = CHIP_ID[15:8];
    else if (idxReg == ID_LOW_IDX)   regValue = CHIP_ID[7:0];
    else if (idxReg == VERSION_IDX)  regValue = {4'h0, CHIP_VER};
    else if (idxReg >= BANK_BASE_IDX) regValue = (bankHit && ldnValid) ? bankValue : LOCKED_READ;
    else                             regValue = 8'h00;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxReg    <= 8'h00;
      ldnReg    <= 8'h00;
      busRdData <= LOCKED_READ;
    end else begin
      if (strobe.clearIdx)     idxReg <= 8'h00;
      else if (strobe.loadIdx) idxReg <= busWrData;
      if (strobe.writeReg && idxReg == LDN_SEL_IDX) ldnReg <= busWrData;
      if (strobe.readLocked)   busRdData <= LOCKED_READ;
      else if (strobe.readIdx) busRdData <= idxReg;
      else if (strobe.readReg) busRdData <= regValue;
    end
  end

endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
  import keyed_cfg_pkg::*;
#(
  parameter int          NUM_LDEV  = 11,
  parameter int          BANK_REGS = 16,
  parameter logic [15:0] CHIP_ID   = 16'h87A5,
  parameter logic [3:0]  CHIP_VER  = 4'h3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       altBase,
  input  logic       busWrEn,
  input  logic       busRdEn,
  input  logic       busAddrSel,
  input  logic [7:0] busWrData,
  output logic [7:0] busRdData
);

  cfgStrobe_t strobe;
  logic       cfgOpen;
  logic [7:0] curIdx, curLdn;

  keyed_cfg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .altBase(altBase),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddrSel(busAddrSel),
    .busWrData(busWrData), .curIdx(curIdx),
    .strobe(strobe), .cfgOpen(cfgOpen)
  );

  keyed_cfg_dp #(
    .NUM_LDEV(NUM_LDEV), .BANK_REGS(BANK_REGS),
    .CHIP_ID(CHIP_ID), .CHIP_VER(CHIP_VER)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWrData(busWrData),
    .busRdData(busRdData), .curIdx(curIdx), .curLdn(curLdn)
  );

endmodule

// File: rtl/keyed_cfg_chk.sv
module keyed_cfg_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busWrEn,
  input logic       busRdEn,
  input logic       busAddrSel,
  input logic [7:0] busWrData,
  input logic [7:0] busRdData,
  input logic       cfgOpen,
  input logic [7:0] curIdx,
  input logic [7:0] curLdn
);

  a_r1_locked_read_ff: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && !cfgOpen) |=> busRdData == 8'hFF);

  a_r1_locked_write_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddrSel && !cfgOpen) |=> $stable(curLdn));

  a_r2_open_from_index_write: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgOpen) |-> $past(busWrEn && !busAddrSel));

  a_r5_index_echo: assert property (@(posedge clk) disable iff (!rstN)
    (cfgOpen && busRdEn && !busAddrSel && !busWrEn) |=> busRdData == $past(curIdx));

  a_r6_id_high: assert property (@(posedge clk) disable iff (!rstN)
    (cfgOpen && busRdEn && busAddrSel && curIdx == 8'h20) |=> busRdData == 8'h87);

  a_r10_close_byte: assert property (@(posedge clk) disable iff (!rstN)
    (cfgOpen && busWrEn && !busAddrSel && busWrData == 8'hAA) |=> !cfgOpen);

  a_r11_close_clears_idx: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cfgOpen) |-> (curIdx == 8'h00 && $stable(curLdn)));

endmodule

bind keyed_cfg_port keyed_cfg_chk u_chk (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
  .busAddrSel(busAddrSel), .busWrData(busWrData), .busRdData(busRdData),
  .cfgOpen(cfgOpen), .curIdx(curIdx), .curLdn(curLdn)
);

// File: tb/keyed_cfg_port_tb_top.sv
module keyed_cfg_port_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       altBase = 1'b0;
  logic       busWrEn = 1'b0;
  logic       busRdEn = 1'b0;
  logic       busAddrSel = 1'b0;
  logic [7:0] busWrData = 8'h00;
  logic [7:0] busRdData;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  keyed_cfg_port dut_i (
    .clk(clk), .rstN(rstN), .altBase(altBase), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busAddrSel(busAddrSel), .busWrData(busWrData),
    .busRdData(busRdData)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wrPort(input logic sel, input logic [7:0] v);
    @(negedge clk);
    busAddrSel = sel; busWrData = v; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rdPort(input logic sel, output logic [7:0] v);
    @(negedge clk);
    busAddrSel = sel; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
    v = busRdData;
  endtask

  task automatic wrReg(input logic [7:0] idx, input logic [7:0] v);
    wrPort(1'b0, idx); wrPort(1'b1, v);
  endtask

  task automatic rdReg(input logic [7:0] idx, output logic [7:0] v);
    wrPort(1'b0, idx); rdPort(1'b1, v);
  endtask

  task automatic sendKey(input logic [7:0] a, b, c, d);
    wrPort(1'b0, a); wrPort(1'b0, b); wrPort(1'b0, c); wrPort(1'b0, d);
  endtask

  task automatic closeByIndex();
    wrPort(1'b0, 8'hAA);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R12 reset rdData", busRdData, 8'hFF);
    rdPort(1'b0, v); check("R1 locked index read", v, 8'hFF);
    rdPort(1'b1, v); check("R1 locked data read", v, 8'hFF);
  endtask

  task automatic t_locked_write();
    logic [7:0] v;
    wrPort(1'b0, 8'h07); wrPort(1'b1, 8'h05);
    sendKey(8'h87, 8'h01, 8'h55, 8'h55);
    rdReg(8'h07, v); check("R1 locked data write dropped", v, 8'h00);
    closeByIndex();
  endtask

  task automatic t_main_key();
    logic [7:0] v;
    altBase = 1'b0;
    sendKey(8'h87, 8'h01, 8'h55, 8'h55);
    wrPort(1'b0, 8'h20); rdPort(1'b0, v);
    check("R2 R5 primary key and index echo", v, 8'h20);
    wrPort(1'b0, 8'h3C); rdPort(1'b0, v);
    check("R5 index echo 0x3C", v, 8'h3C);
  endtask

  task automatic t_chip_id();
    logic [7:0] v;
    rdReg(8'h20, v); check("R6 id high", v, 8'h87);
    rdReg(8'h21, v); check("R6 id low", v, 8'hA5);
    rdReg(8'h22, v); check("R6 version", v, 8'h03);
    wrReg(8'h20, 8'h11); rdPort(1'b1, v); check("R6 id read-only", v, 8'h87);
    wrReg(8'h22, 8'hFF); rdPort(1'b1, v); check("R6 version read-only", v, 8'h03);
  endtask

  task automatic t_banks();
    logic [7:0] v;
    wrReg(8'h07, 8'h01); wrReg(8'h30, 8'h5A);
    wrReg(8'h07, 8'h02); wrReg(8'h30, 8'hC3);
    rdReg(8'h30, v); check("R7 device 2 bank", v, 8'hC3);
    wrReg(8'h07, 8'h01); rdReg(8'h30, v); check("R7 device 1 bank independent", v, 8'h5A);
    wrReg(8'h07, 8'h0A); wrReg(8'h3F, 8'h77); rdReg(8'h3F, v);
    check("R7 top device last bank reg", v, 8'h77);
    rdReg(8'h07, v); check("R7 ldn readback", v, 8'h0A);
  endtask

  task automatic t_missing_dev();
    logic [7:0] v;
    wrReg(8'h07, 8'h0B); wrReg(8'h30, 8'h12);
    rdReg(8'h30, v); check("R8 unimplemented device reads FF", v, 8'hFF);
    wrReg(8'h07, 8'h01); rdReg(8'h40, v); check("R8 beyond bank reads FF", v, 8'hFF);
    rdReg(8'h30, v); check("R8 write to missing device ignored", v, 8'h5A);
  endtask

  task automatic t_close_reg();
    logic [7:0] v;
    wrReg(8'h07, 8'h03);
    wrReg(8'h02, 8'h01); rdPort(1'b0, v); check("R9 other value keeps open", v, 8'h02);
    wrPort(1'b1, 8'h02); rdPort(1'b0, v); check("R9 close register locks", v, 8'hFF);
    sendKey(8'h87, 8'h01, 8'h55, 8'h55);
    rdPort(1'b0, v); check("R11 index cleared on close", v, 8'h00);
    rdReg(8'h07, v); check("R11 ldn kept on close", v, 8'h03);
  endtask

  task automatic t_close_index();
    logic [7:0] v;
    closeByIndex(); rdPort(1'b0, v); check("R10 close byte locks", v, 8'hFF);
  endtask

  task automatic t_legacy_key();
    logic [7:0] v;
    wrPort(1'b0, 8'h87); wrPort(1'b0, 8'h87);
    wrPort(1'b0, 8'h21); rdPort(1'b0, v); check("R3 double 0x87 unlocks", v, 8'h21);
    closeByIndex();
  endtask

  task automatic t_alt_base();
    logic [7:0] v;
    altBase = 1'b1;
    sendKey(8'h87, 8'h01, 8'h55, 8'h55);
    rdPort(1'b0, v); check("R2 primary last byte rejected on alt base", v, 8'hFF);
    sendKey(8'h87, 8'h01, 8'h55, 8'hAA);
    wrPort(1'b0, 8'h22); rdPort(1'b0, v); check("R2 alt base key unlocks", v, 8'h22);
    closeByIndex();
    altBase = 1'b0;
  endtask

  task automatic t_key_errors();
    logic [7:0] v;
    wrPort(1'b0, 8'h87); wrPort(1'b0, 8'h01); wrPort(1'b0, 8'h12);
    wrPort(1'b0, 8'h55); wrPort(1'b0, 8'h55);
    rdPort(1'b0, v); check("R4 wrong byte resets matcher", v, 8'hFF);
    wrPort(1'b0, 8'h87); wrPort(1'b0, 8'h01);
    sendKey(8'h87, 8'h01, 8'h55, 8'h55);
    wrPort(1'b0, 8'h24); rdPort(1'b0, v); check("R4 0x87 restarts sequence", v, 8'h24);
    closeByIndex();
    wrPort(1'b0, 8'h87); wrPort(1'b0, 8'h01); wrPort(1'b0, 8'h55); wrPort(1'b0, 8'h33);
    wrPort(1'b0, 8'h87);
    rdPort(1'b0, v); check("R4 partial key stays locked", v, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_locked_write();
    t_main_key();
    t_chip_id();
    t_banks();
    t_missing_dev();
    t_close_reg();
    t_close_index();
    t_legacy_key();
    t_alt_base();
    t_key_errors();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule